// File: doc/BRIEF.md
# Flow-Control Credit Packet Generator

This block builds the six-byte credit packet that one data virtual lane sends to its link partner. On a request from the lane, or when a refresh timer runs out, it takes a copy of the lane's blocks-sent total, its credit limit and its lane number. It puts a fixed opcode in front of them and adds a 16-bit CRC. It then raises a ready flag. A transmit arbiter reads the packet one byte per cycle, most significant byte first. A pulse on the read strobe moves the block on to the next byte. One instance serves each data lane. The management lane has no instance.

The link state logic gates the block with a single enable. While the enable is low, no packet is built and any pending packet is dropped. The refresh timer restarts each time a packet has been fully read. If the lane asks for nothing more, the timer forces a new packet 65,536 clocks later. If the lane asks again while a packet is waiting but not yet started, the copy is refreshed in place. If the lane asks again while the packet is being read, one follow-up packet is marked to start as soon as the current one ends.

Top module: `fc_credit_pkt_gen`

## Requirements
- R1: After reset, `pkt_ready` is 0, `pkt_last` is 0 and `pkt_byte` is 0x00.
- R2: When `link_pkt_en` is 1, no packet is pending and `gen_req` is 1 at a clock edge, `pkt_ready` is 1 after that edge.
- R3: The first four bytes are, in transmit order, {opcode 4'h0, fctbs[11:8]}, fctbs[7:0], {vl_num[3:0], fccl[11:8]} and fccl[7:0]. The values are those sampled in the cycle the packet was built.
- R4: Bytes 5 and 6 are the CRC, high byte first. The CRC uses polynomial 0x100B and a register preset to 0xFFFF. It runs over the 32 header bits, most significant bit first, and the result is bit-inverted.
- R5: Each cycle with `pkt_ready` and `byte_rd` both 1 advances one byte. `pkt_last` is 1 exactly while the sixth byte is shown. After the sixth byte is read, `pkt_ready` falls on the next edge unless a follow-up packet is due (R10).
- R6: `byte_rd` has no effect while `pkt_ready` is 0. A later packet still starts at its first byte.
- R7: While `link_pkt_en` is 0, `gen_req` is ignored and `pkt_ready` is 0 from the next edge, so a pending packet is dropped.
- R8: Without requests and with the enable held, `pkt_ready` rises 65,536 clock edges after the edge on which the sixth byte was read.
- R9: A request while a packet is ready but none of its bytes has been read replaces the copied fields and the CRC. Only one packet is then sent.
- R10: A request made while a packet is being read causes a new packet to be built at the edge that reads the sixth byte. That packet uses the field inputs present in that cycle, and `pkt_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_pkt_en | input | 1 | Link-packet enable from the link state logic |
| gen_req | input | 1 | Packet request from the virtual lane |
| fctbs | input | 12 | Total blocks sent by the lane |
| fccl | input | 12 | Credit limit to advertise |
| vl_num | input | 4 | Lane number |
| byte_rd | input | 1 | Arbiter strobe: consume the shown byte |
| pkt_ready | output | 1 | A packet is available |
| pkt_byte | output | 8 | Current packet byte (0 when not ready) |
| pkt_last | output | 1 | The shown byte is the sixth |

## Verification
The bench builds packets from a set of field patterns: all zeros, all ones, alternating bits and walking values. The all-zero and all-one patterns catch a wrong CRC preset or a missing final inversion. The alternating and walking patterns catch swapped fields, swapped nibbles or a wrong byte order. Separate tests check the three cases that decide when fields are copied: a second request before reading starts, a request during reading, and a refresh with no request. These tests tell apart a refreshed copy, a follow-up packet and a timer-driven packet. Disable and idle-read tests check that nothing leaks out when the block must stay quiet.

// File: rtl/fcpg_pkg.sv
package fcpg_pkg;
  localparam int CNT_W     = 12;
  localparam int LANE_W    = 4;
  localparam int OP_W      = 4;
  localparam int HDR_W     = OP_W + CNT_W + LANE_W + CNT_W;
  localparam int CRC_W     = 16;
  localparam int PKT_BYTES = (HDR_W + CRC_W) / 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HELD,
    ST_SEND
  } gen_state_t;

  typedef struct packed {
    logic [OP_W-1:0]   opcode;
    logic [CNT_W-1:0]  sent_total;
    logic [LANE_W-1:0] lane;
    logic [CNT_W-1:0]  credit_limit;
  } fc_hdr_t;
endpackage

// File: rtl/fcpg_crc16.sv
module fcpg_crc16 #(
  parameter int          DATA_W = 32,
  parameter logic [15:0] POLY   = 16'h100B,
  parameter logic [15:0] INIT   = 16'hFFFF
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [15:0]       crc_o
);
  logic [15:0] acc;

  always_comb begin
    acc = INIT;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (acc[15] ^ data_i[i]) acc = {acc[14:0], 1'b0} ^ POLY;
      else                     acc = {acc[14:0], 1'b0};
    end
    crc_o = ~acc;
  end
endmodule

// File: rtl/fcpg_refresh_timer.sv
module fcpg_refresh_timer #(
  parameter int LIMIT = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic done_o
);
  localparam int            CW    = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST  = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || restart_i) cnt_d = '0;
    else if (cnt_q != LAST)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == LAST);

  // R8
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && run_i && !restart_i) |=> done_o);
  // R8
  tmr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && LIMIT > 1) |=> !done_o);
endmodule

// File: rtl/fcpg_byte_ser.sv
module fcpg_byte_ser #(
  parameter int NBYTES = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  adv_i,
  input  logic [8*NBYTES-1:0]   frame_i,
  output logic [7:0]            byte_o,
  output logic                  last_o
);
  localparam int            IW   = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [IW-1:0] LAST = IW'(NBYTES - 1);

  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (clr_i)      idx_d = '0;
    else if (adv_i) idx_d = (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  always_comb begin
    byte_o = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (idx_q == IW'(i)) byte_o = frame_i[8*(NBYTES-1-i) +: 8];
    end
  end

  assign last_o = (idx_q == LAST);

  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST);
  // R6
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !clr_i) |=> $stable(idx_q));
endmodule

// File: rtl/fc_credit_pkt_gen.sv
module fc_credit_pkt_gen
  import fcpg_pkg::*;
#(
  parameter logic [3:0]  OPCODE         = 4'h0,
  parameter int          REFRESH_CYCLES = 65536,
  parameter logic [15:0] CRC_POLY       = 16'h100B,
  parameter logic [15:0] CRC_INIT       = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_pkt_en,
  input  logic        gen_req,
  input  logic [11:0] fctbs,
  input  logic [11:0] fccl,
  input  logic [3:0]  vl_num,
  input  logic        byte_rd,
  output logic        pkt_ready,
  output logic [7:0]  pkt_byte,
  output logic        pkt_last
);
  localparam int FRAME_W = 8 * PKT_BYTES;

  gen_state_t         st_q, st_d;
  logic               rerun_q, rerun_d;
  logic [FRAME_W-1:0] frame_q;
  logic               load, adv, clr, handoff;
  logic               tmr_done, ser_last;
  logic [7:0]         ser_byte;
  fc_hdr_t            hdr;
  logic [CRC_W-1:0]   crc;

  assign hdr = '{opcode: OPCODE, sent_total: fctbs, lane: vl_num, credit_limit: fccl};

  fcpg_crc16 #(.DATA_W(HDR_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .data_i (hdr),
    .crc_o  (crc)
  );

  fcpg_refresh_timer #(.LIMIT(REFRESH_CYCLES)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (link_pkt_en),
    .restart_i (handoff),
    .done_o    (tmr_done)
  );

  fcpg_byte_ser #(.NBYTES(PKT_BYTES)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr),
    .adv_i   (adv),
    .frame_i (frame_q),
    .byte_o  (ser_byte),
    .last_o  (ser_last)
  );

  always_comb begin
    st_d    = st_q;
    rerun_d = rerun_q;
    load    = 1'b0;
    adv     = 1'b0;
    clr     = 1'b0;
    handoff = 1'b0;
    if (!link_pkt_en) begin
      st_d    = ST_IDLE;
      rerun_d = 1'b0;
      clr     = 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (gen_req || tmr_done) begin
            load = 1'b1;
            clr  = 1'b1;
            st_d = ST_HELD;
          end
        end
        ST_HELD: begin
          if (byte_rd) begin
            adv     = 1'b1;
            st_d    = ST_SEND;
            rerun_d = gen_req;
          end else if (gen_req) begin
            load = 1'b1;
          end
        end
        ST_SEND: begin
          if (gen_req) rerun_d = 1'b1;
          if (byte_rd) begin
            adv = 1'b1;
            if (ser_last) begin
              handoff = 1'b1;
              if (rerun_q || gen_req) begin
                load    = 1'b1;
                rerun_d = 1'b0;
                st_d    = ST_HELD;
              end else begin
                st_d = ST_IDLE;
              end
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      rerun_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      rerun_q <= rerun_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    frame_q <= '0;
    else if (load) frame_q <= {hdr, crc};
  end

  assign pkt_ready = (st_q != ST_IDLE);
  assign pkt_byte  = pkt_ready ? ser_byte : 8'h00;
  assign pkt_last  = pkt_ready && ser_last;

  // R7
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_pkt_en |=> !pkt_ready);
  // R2
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_ready) |-> $past(gen_req || tmr_done));
  // R5
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEND && link_pkt_en && !(byte_rd && ser_last)) |=> $stable(frame_q));
  // R5
  last_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_last && byte_rd && link_pkt_en && !gen_req && !rerun_q) |=> !pkt_ready);
  // R10
  rerun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_last && byte_rd && link_pkt_en && rerun_q) |=> (pkt_ready && !pkt_last));
endmodule

// File: tb/sim_fc_credit_pkt_gen.sv
module sim_fc_credit_pkt_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        link_pkt_en, gen_req, byte_rd;
  logic [11:0] fctbs, fccl;
  logic [3:0]  vl_num;
  logic        pkt_ready, pkt_last;
  logic [7:0]  pkt_byte;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  fc_credit_pkt_gen u0 (
    .clk(clk), .rst_n(rst_n), .link_pkt_en(link_pkt_en), .gen_req(gen_req),
    .fctbs(fctbs), .fccl(fccl), .vl_num(vl_num), .byte_rd(byte_rd),
    .pkt_ready(pkt_ready), .pkt_byte(pkt_byte), .pkt_last(pkt_last)
  );

  // {fctbs, fccl, vl}
  localparam logic [27:0] VEC [6] = '{
    {12'h000, 12'h000, 4'h0},
    {12'hFFF, 12'hFFF, 4'hE},
    {12'hAAA, 12'h555, 4'h5},
    {12'h123, 12'h456, 4'h7},
    {12'h801, 12'h010, 4'h1},
    {12'h07F, 12'hF80, 4'hA}
  };

  function automatic logic [47:0] exp_frame(input logic [11:0] t, input logic [11:0] l,
                                            input logic [3:0] v);
    logic [31:0] h;
    logic [15:0] c;
    h = {4'h0, t, v, l};
    c = 16'hFFFF;
    for (int i = 31; i >= 0; i--) begin
      logic fb;
      fb = c[15] ^ h[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h100B;
    end
    return {h, ~c};
  endfunction

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_req(input logic [11:0] t, input logic [11:0] l, input logic [3:0] v);
    fctbs = t; fccl = l; vl_num = v; gen_req = 1'b1;
    @(negedge clk);
    gen_req = 1'b0;
  endtask

  task automatic read_bytes(input string tag, input logic [47:0] exp, input int first,
                            input int count);
    for (int i = first; i < first + count; i++) begin
      check({tag, " R5 ready"}, {47'd0, pkt_ready}, 48'd1);
      check({tag, " R3/R4 byte"}, {40'd0, pkt_byte}, {40'd0, exp[47-8*i -: 8]});
      check({tag, " R5 last"}, {47'd0, pkt_last}, {47'd0, (i == 5)});
      byte_rd = 1'b1;
      @(negedge clk);
    end
    byte_rd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; link_pkt_en = 1'b0; gen_req = 1'b0; byte_rd = 1'b0;
    fctbs = '0; fccl = '0; vl_num = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready", {47'd0, pkt_ready}, 48'd0);
    check("R1 byte", {40'd0, pkt_byte}, 48'd0);
    check("R1 last", {47'd0, pkt_last}, 48'd0);

    link_pkt_en = 1'b1;
    @(negedge clk);
    // R6 reads while idle are ignored
    byte_rd = 1'b1;
    repeat (3) @(negedge clk);
    byte_rd = 1'b0;
    check("R6 idle ready", {47'd0, pkt_ready}, 48'd0);
    send_req(12'h3C5, 12'hA0F, 4'h9);
    check("R2 ready after req", {47'd0, pkt_ready}, 48'd1);
    read_bytes("R6 first byte", exp_frame(12'h3C5, 12'hA0F, 4'h9), 0, 6);
    check("R5 ready drop", {47'd0, pkt_ready}, 48'd0);

    // vector table: R2 R3 R4 R5
    for (int k = 0; k < 6; k++) begin
      send_req(VEC[k][27:16], VEC[k][15:4], VEC[k][3:0]);
      check("R2 vec ready", {47'd0, pkt_ready}, 48'd1);
      read_bytes("vec", exp_frame(VEC[k][27:16], VEC[k][15:4], VEC[k][3:0]), 0, 6);
      check("R5 vec drop", {47'd0, pkt_ready}, 48'd0);
    end

    // R9 request while held replaces fields
    send_req(12'h111, 12'h222, 4'h3);
    send_req(12'h444, 12'h555, 4'h6);
    read_bytes("R9 refreshed", exp_frame(12'h444, 12'h555, 4'h6), 0, 6);
    check("R9 single packet", {47'd0, pkt_ready}, 48'd0);

    // R10 request during readout
    send_req(12'h0F0, 12'h00F, 4'h2);
    read_bytes("R10 head", exp_frame(12'h0F0, 12'h00F, 4'h2), 0, 2);
    send_req(12'hBEE, 12'hCAB, 4'hD);
    read_bytes("R10 tail", exp_frame(12'h0F0, 12'h00F, 4'h2), 2, 4);
    check("R10 ready kept", {47'd0, pkt_ready}, 48'd1);
    read_bytes("R10 follow", exp_frame(12'hBEE, 12'hCAB, 4'hD), 0, 6);

    // R7 disable drops pending packet and ignores requests
    send_req(12'h777, 12'h888, 4'h4);
    link_pkt_en = 1'b0;
    @(negedge clk);
    check("R7 drop", {47'd0, pkt_ready}, 48'd0);
    send_req(12'h999, 12'h999, 4'h9);
    check("R7 req ignored", {47'd0, pkt_ready}, 48'd0);
    link_pkt_en = 1'b1;
    @(negedge clk);
    check("R7 re-enable idle", {47'd0, pkt_ready}, 48'd0);

    // R8 refresh 65536 edges after handoff
    send_req(12'h246, 12'h8AC, 4'hB);
    fctbs = 12'h135; fccl = 12'h79B; vl_num = 4'hC;
    read_bytes("R8 seed", exp_frame(12'h246, 12'h8AC, 4'hB), 0, 6);
    repeat (65535) @(negedge clk);
    check("R8 not yet", {47'd0, pkt_ready}, 48'd0);
    @(negedge clk);
    check("R8 refresh ready", {47'd0, pkt_ready}, 48'd1);
    read_bytes("R8 refresh", exp_frame(12'h135, 12'h79B, 4'hC), 0, 6);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule